// File: doc/BRIEF.md
# Address-Decoded Accumulator ALU

This block is a register-window peripheral for a processor whose only instruction is a move. It holds an accumulator with carry and zero flags, and it computes purely as a side effect of stores: the low address of an eight-entry window loads the accumulator, and each of the seven addresses above it combines the stored value with the accumulator through one fixed operation. The result replaces the accumulator in place, so a chain of stores builds up an expression without any opcode.

Software reads the result back through the same bus. Any address read returns the accumulator, and reading has no side effect. The zero and carry flags are also brought out as pins, so that a separate branch unit can select jump targets from them without a bus read.

Top module: `accWindowAlu`

## Requirements
- R1: After reset the accumulator, the carry flag and the zero flag are all 0.
- R2: A write to window offset 0 loads the written value into the accumulator unchanged.
- R3: A write to offset 1 stores acc AND data, to offset 2 stores acc OR data, and to offset 3 stores acc XOR data.
- R4: A write to offset 4 stores (acc + data) modulo 2^DATA_W, and the carry flag takes the carry-out of that addition.
- R5: A write to offset 5 stores (acc + data + carry) modulo 2^DATA_W, and the carry flag takes its carry-out.
- R6: A write to offset 6 stores (acc - data) modulo 2^DATA_W, and the carry flag becomes 1 exactly when data, as an unsigned number, exceeds acc.
- R7: A write to offset 7 stores (acc - data - carry) modulo 2^DATA_W, and the carry flag becomes 1 exactly when data + carry exceeds acc.
- R8: After every accepted write, including a load, the zero flag is 1 exactly when the new accumulator value is 0.
- R9: Writes to offsets 0 to 3 leave the carry flag unchanged.
- R10: A write with wrEn low, or to an address outside BASE_ADDR to BASE_ADDR+7, changes neither the accumulator nor the flags.
- R11: rdData equals the accumulator for every address, and reading changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Bus address |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, always the accumulator |
| zeroFlag | output | 1 | Zero flag |
| carryFlag | output | 1 | Carry / borrow flag |

## Verification
The assertions watch on every cycle that an idle or out-of-window cycle leaves the accumulator and flags untouched, that a load copies the data, that the zero flag follows the new accumulator after each write, and that logic and load writes keep the carry. The arithmetic results, the carry and borrow rules including the carry-in of the chained forms, and the reset state are shown only by the bench, which replays random and directed store sequences against a reference model and compares the read port and both flag pins after each one.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int WINDOW = 8;
  localparam int OFFSET_W = $clog2(WINDOW);

  typedef enum logic [OFFSET_W-1:0] {
    OP_LOAD = 3'd0,
    OP_AND  = 3'd1,
    OP_OR   = 3'd2,
    OP_XOR  = 3'd3,
    OP_ADD  = 3'd4,
    OP_ADC  = 3'd5,
    OP_SUB  = 3'd6,
    OP_SBB  = 3'd7
  } aluOp_e;

  typedef struct packed {
    logic   commit;
    aluOp_e op;
  } aluStrobe_t;
endpackage

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import acc_alu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output aluStrobe_t        strobe
);
  logic [ADDR_W-1:0] relAddr;
  logic              inWindow;

  always_comb begin
    relAddr  = addr - BASE_ADDR;
    inWindow = (addr >= BASE_ADDR) && (relAddr < ADDR_W'(WINDOW));
    strobe.commit = wrEn && inWindow;
    strobe.op     = aluOp_e'(relAddr[OFFSET_W-1:0]);
  end
endmodule

// File: rtl/accAluPath.sv
module accAluPath
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc,
  output logic              carry,
  output logic              zero
);
  logic [DATA_W:0]   addFull;
  logic [DATA_W:0]   subFull;
  logic [DATA_W-1:0] nextAcc;
  logic              nextCarry;
  logic              carryIn;

  always_comb begin
    carryIn   = (strobe.op == OP_ADC || strobe.op == OP_SBB) ? carry : 1'b0;
    addFull   = {1'b0, acc} + {1'b0, operand} + {{DATA_W{1'b0}}, carryIn};
    subFull   = {1'b0, acc} - {1'b0, operand} - {{DATA_W{1'b0}}, carryIn};
    nextAcc   = acc;
    nextCarry = carry;
    unique case (strobe.op)
      OP_LOAD: nextAcc = operand;
      OP_AND:  nextAcc = acc & operand;
      OP_OR:   nextAcc = acc | operand;
      OP_XOR:  nextAcc = acc ^ operand;
      OP_ADD, OP_ADC: begin
        nextAcc   = addFull[DATA_W-1:0];
        nextCarry = addFull[DATA_W];
      end
      OP_SUB, OP_SBB: begin
        nextAcc   = subFull[DATA_W-1:0];
        nextCarry = subFull[DATA_W];
      end
      default: nextAcc = acc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      carry <= 1'b0;
      zero  <= 1'b0;
    end else if (strobe.commit) begin
      acc   <= nextAcc;
      carry <= nextCarry;
      zero  <= (nextAcc == '0);
    end
  end

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.commit |=> ($stable(acc) && $stable(carry) && $stable(zero)));

  p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && strobe.op == OP_LOAD) |=> (acc == $past(operand)));

  p_zero_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |=> (zero == (acc == '0)));

  p_logic_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && !strobe.op[OFFSET_W-1]) |=> $stable(carry));
endmodule

// File: rtl/accWindowAlu.sv
module accWindowAlu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              zeroFlag,
  output logic              carryFlag
);
  aluStrobe_t strobe;
  logic [DATA_W-1:0] accQ;

  accAluCtrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_ctrl (
    .addr(addr), .wrEn(wrEn), .strobe(strobe)
  );

  accAluPath #(.DATA_W(DATA_W)) i_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .operand(wrData),
    .acc(accQ), .carry(carryFlag), .zero(zeroFlag)
  );

  assign rdData = accQ;
endmodule

// File: tb/test_accWindowAlu.sv
module test_accWindowAlu;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] BASE = 8'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic zeroFlag, carryFlag;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] mAcc = '0;
  logic mCarry = 1'b0;
  logic mZero = 1'b0;

  always #2.5 clk = ~clk;

  accWindowAlu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE)) i_accWindowAlu (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .zeroFlag(zeroFlag), .carryFlag(carryFlag)
  );

  function automatic string reqOf(input int off);
    case (off)
      0: return "R2";
      1, 2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // reference model step; returns 1 if the write was accepted
  function automatic bit modelWrite(input logic [ADDR_W-1:0] a, input logic we,
                                    input logic [DATA_W-1:0] d);
    logic [DATA_W:0] r;
    int off;
    if (!we || a < BASE || a > BASE + 7) return 0;
    off = int'(a - BASE);
    case (off)
      0: mAcc = d;
      1: mAcc = mAcc & d;
      2: mAcc = mAcc | d;
      3: mAcc = mAcc ^ d;
      4, 5: begin
        r = {1'b0, mAcc} + {1'b0, d} + ((off == 5) ? {{DATA_W{1'b0}}, mCarry} : '0);
        mAcc = r[DATA_W-1:0]; mCarry = r[DATA_W];
      end
      default: begin
        mCarry = ({1'b0, d} + ((off == 7) ? {{DATA_W{1'b0}}, mCarry} : '0)) > {1'b0, mAcc};
        mAcc = mAcc - d - ((off == 7) ? {{(DATA_W-1){1'b0}}, mCarry_prev(off)} : '0);
      end
    endcase
    mZero = (mAcc == '0);
    return 1;
  endfunction

  // placeholder-free helper: carry used by SBB must be the value before update
  logic savedCarry;
  function automatic logic mCarry_prev(input int off);
    return savedCarry;
  endfunction

  task automatic checkAll(input string req);
    checks++;
    if (rdData !== mAcc || zeroFlag !== mZero || carryFlag !== mCarry) begin
      errors++;
      $display("FAIL %s: acc=%h z=%b c=%b expected acc=%h z=%b c=%b",
               req, rdData, zeroFlag, carryFlag, mAcc, mZero, mCarry);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic we,
                          input logic [DATA_W-1:0] d, input string req);
    bit taken;
    @(negedge clk);
    addr = a; wrEn = we; wrData = d;
    savedCarry = mCarry;
    taken = modelWrite(a, we, d);
    @(negedge clk);
    wrEn = 1'b0;
    checkAll(req);
  endtask

  task automatic opWrite(input int off, input logic [DATA_W-1:0] d);
    busWrite(BASE + ADDR_W'(off), 1'b1, d, reqOf(off));
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    checkAll("R1");
    rst_n = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R2 load, R8 zero after load
    opWrite(0, 16'h1234);
    opWrite(0, 16'h0000);
    checkAll("R8");
    // R3 logic ops
    opWrite(0, 16'hF0F0); opWrite(1, 16'hFF00);
    opWrite(2, 16'h000F); opWrite(3, 16'hF00F);
    // R4 overflow -> zero with carry, R8
    opWrite(0, 16'hFFFF); opWrite(4, 16'h0001);
    // R9 logic and load keep carry=1
    opWrite(2, 16'h0005); opWrite(0, 16'h0003); checkAll("R9");
    // R5 carry-in used
    opWrite(5, 16'h0001);
    // R6 equal -> zero, no borrow; larger -> borrow
    opWrite(0, 16'h0010); opWrite(6, 16'h0010);
    opWrite(6, 16'h0001);
    // R7 borrow via carry-in: acc=5, carry=1, data=5
    opWrite(0, 16'h0005); opWrite(7, 16'h0005);
    opWrite(7, 16'h0000);
    // R10 ignored writes
    busWrite(BASE - 1, 1'b1, 16'hAAAA, "R10");
    busWrite(BASE + 8, 1'b1, 16'hBBBB, "R10");
    busWrite(BASE, 1'b0, 16'hCCCC, "R10");
    // R11 reads at many addresses
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      addr = ADDR_W'(i * 17);
      #1;
      checkAll("R11");
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] a;
      int sel = $urandom_range(0, 9);
      a = (sel < 9) ? BASE + ADDR_W'($urandom_range(0, 7)) : ADDR_W'($urandom);
      busWrite(a, ($urandom_range(0, 7) != 0), DATA_W'($urandom),
               (a >= BASE && a <= BASE + 7) ? reqOf(int'(a - BASE)) : "R10");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule